// File: doc/BRIEF.md
# Error-Correcting Banked Word Memory

This block is a synchronous word memory that keeps 32-bit data words safe from bit upsets. A write encodes the incoming word into a 39-bit codeword and stores it. The codeword holds six Hamming check bits and one extra parity bit over the whole word. A read fetches the stored codeword and recomputes the syndrome. It repairs any single flipped bit, and it reports a double flip without changing the data. Each read sets one of two flags: corrected or uncorrectable.

The storage is split into a parameterised number of equal banks, sixteen by default. The upper address bits pick the bank and the lower bits pick the word inside it. A sleep input holds the array in retention. While sleep is high the contents are kept and every access is refused. A write-side flip mask lets a test corrupt chosen codeword bits as they are stored, so the repair logic can be exercised from the ports.

Top module: `ecc_sram_top`

## Requirements
- R1: Codeword layout is fixed. Bit 0 is parity over codeword bits 1..38. The check bits sit at bit positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the other positions in rising order, so data bit 0 is at position 3, bit 1 at position 5 and bit 31 at position 38.
- R2: When `rd_en` is high and `sleep` is low at a rising edge, `rd_valid` is high after that edge for one cycle and `rd_data` carries the word. In every other cycle `rd_valid` is low, and `rd_data` holds its value until the next accepted read.
- R3: A write accepted at a rising edge is fully stored by that edge. A read accepted at the next edge returns the new word.
- R4: If exactly one data-bit position of the codeword is flipped, the read returns the original word with `err_corr`=1 and `err_uncorr`=0.
- R5: If exactly one check bit or the overall-parity bit is flipped, the read returns the original word with `err_corr`=1 and `err_uncorr`=0.
- R6: If exactly two codeword bits are flipped, the read returns the stored data bits as they are, without repair, with `err_uncorr`=1 and `err_corr`=0.
- R7: A read of a codeword written with a zero flip mask returns the written word with both flags low.
- R8: `addr[7:4]` selects one of 16 banks and `addr[3:0]` selects the word inside it. All 256 addresses hold independent words.
- R9: While `sleep` is high at an edge, `wr_en` and `rd_en` are ignored, `rd_valid` stays low and no stored word changes. An access presented at the first edge with `sleep` low is accepted.
- R10: A read and a write to the same address at the same edge return the word stored before that write. The written word is visible to later reads.
- R11: On an accepted write, bit n of `flip_mask` inverts bit n of the stored codeword.
- R12: While `rst_n` is low and after its release, `rd_valid`, `err_corr` and `err_uncorr` are low until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Retention request; blocks all access |
| addr | input | 8 | Word address: bank in upper bits, word in lower bits |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_data | input | 32 | Word to be written |
| flip_mask | input | 39 | Codeword bits to invert on write (fault injection) |
| rd_data | output | 32 | Corrected read word |
| rd_valid | output | 1 | Read result present |
| err_corr | output | 1 | Single-bit error repaired on this read |
| err_uncorr | output | 1 | Double-bit error found on this read |

## Verification
Two functions can meet at one clock edge: a read and a write aimed at the same address, or a sleep edge and an access. The bench stores one word, then raises `rd_en` and `wr_en` together with a second word at that address, and expects the first word back and then the second on the next read. It also drops `sleep` in the same cycle that it presents a read. It expects that read to be served, while every request made during sleep yields no `rd_valid` and leaves the stored word unchanged.

// File: rtl/ecc_sram_pkg.sv
// Shared constants and helpers for the error-correcting word memory.
// Assumes a 32-bit data word; the codeword width is derived from it.
package ecc_sram_pkg;
    localparam int DATA_W = 32;
    localparam int PAR_W  = 6;
    localparam int CW_W   = DATA_W + PAR_W + 1;

    typedef logic [CW_W-1:0]   code_t;
    typedef logic [DATA_W-1:0] word_t;

    // True when p is a check-bit position (a power of two, p >= 1).
    function automatic bit is_check_pos(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction
endpackage

// File: rtl/ecc_encoder.sv
// Builds the stored codeword from a data word.
// Bit 0 holds overall parity, the power-of-two positions hold Hamming check
// bits, and data fills the other positions in rising order. Pure combinational.
module ecc_encoder
    import ecc_sram_pkg::*;
(
    input  word_t data_in,
    output code_t code_out
);
    // Scatter the data bits, then fill the check bits and the overall parity.
    always_comb begin
        int    d;
        logic  par;
        code_out = '0;
        d = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_check_pos(p)) begin
                code_out[p] = data_in[d];
                d++;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            par = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (!is_check_pos(p) && (((p >> k) & 1) == 1))
                    par = par ^ code_out[p];
            end
            code_out[1 << k] = par;
        end
        code_out[0] = ^code_out[CW_W-1:1];
    end
endmodule

// File: rtl/ecc_decoder.sv
// Checks a codeword read from the array and repairs a single flipped bit.
// A nonzero syndrome with even overall parity, or a syndrome that points past
// the codeword, is reported as uncorrectable and the data passes through raw.
// Pure combinational.
module ecc_decoder
    import ecc_sram_pkg::*;
(
    input  code_t code_in,
    output word_t data_out,
    output logic  single_err,
    output logic  double_err
);
    logic [PAR_W-1:0] syndrome;
    logic             parity_bad;
    code_t            flip_sel;
    code_t            fixed;

    // Syndrome: XOR tree per check bit over the positions it covers.
    always_comb begin
        for (int k = 0; k < PAR_W; k++) begin
            syndrome[k] = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> k) & 1) == 1)
                    syndrome[k] = syndrome[k] ^ code_in[p];
            end
        end
        parity_bad = ^code_in;
    end

    // Position decoder: one-hot bit to invert, only when overall parity fails.
    always_comb begin
        for (int p = 0; p < CW_W; p++)
            flip_sel[p] = parity_bad && (int'(syndrome) == p);
    end

    // Per-bit repair: choose the bit or its inverse.
    for (genvar g = 0; g < CW_W; g++) begin : g_fix
        assign fixed[g] = flip_sel[g] ? ~code_in[g] : code_in[g];
    end

    // Gather data bits back from their codeword positions.
    always_comb begin
        int d;
        data_out = '0;
        d = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_check_pos(p)) begin
                data_out[d] = fixed[p];
                d++;
            end
        end
    end

    // Classify the outcome.
    always_comb begin
        single_err = parity_bad && (int'(syndrome) < CW_W);
        double_err = (!parity_bad && (syndrome != '0))
                  || (parity_bad && (int'(syndrome) >= CW_W));
    end
endmodule

// File: rtl/ecc_sram_bank.sv
// One storage bank: a plain register array with a synchronous write port and
// a registered read port. A read and write at one edge return the old word.
// Contents are not reset, as in a real memory array.
module ecc_sram_bank #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 39,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_word,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store on write; capture the addressed word on read (old value on overlap).
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wr_word;
        if (rd_en)
            rd_word <= mem[addr];
    end
endmodule

// File: rtl/ecc_sram_top.sv
// Error-correcting banked word memory. Writes are encoded and stored in one
// cycle; reads return corrected data one cycle after acceptance. Sleep blocks
// every access and keeps contents. Assumes synchronous active-low reset.
module ecc_sram_top
    import ecc_sram_pkg::*;
#(
    parameter int NUM_BANKS  = 16,
    parameter int BANK_DEPTH = 16,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int WORD_W    = $clog2(BANK_DEPTH),
    localparam int ADDR_W    = BANK_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wr_data,
    input  logic [38:0]       flip_mask,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              err_corr,
    output logic              err_uncorr
);
    logic              wr_go;
    logic              rd_go;
    logic [BANK_W-1:0] bank_sel;
    logic [WORD_W-1:0] word_sel;
    code_t             enc_word;
    code_t             store_word;
    code_t             bank_q [NUM_BANKS];
    logic [BANK_W-1:0] rd_bank_q;
    code_t             rd_code;
    logic              dec_single;
    logic              dec_double;

    // Gate requests with sleep and split the address.
    always_comb begin
        wr_go      = wr_en && !sleep;
        rd_go      = rd_en && !sleep;
        bank_sel   = addr[ADDR_W-1 -: BANK_W];
        word_sel   = addr[WORD_W-1:0];
        store_word = enc_word ^ flip_mask;
    end

    ecc_encoder i_enc (
        .data_in  (wr_data),
        .code_out (enc_word)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ecc_sram_bank #(
            .DEPTH (BANK_DEPTH),
            .WIDTH (CW_W)
        ) i_bank (
            .clk     (clk),
            .wr_en   (wr_go && (bank_sel == BANK_W'(b))),
            .rd_en   (rd_go && (bank_sel == BANK_W'(b))),
            .addr    (word_sel),
            .wr_word (store_word),
            .rd_word (bank_q[b])
        );
    end

    // Remember which bank answers and mark the result valid next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_bank_q <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_bank_q <= bank_sel;
        end
    end

    // Output multiplexer across banks.
    always_comb rd_code = bank_q[rd_bank_q];

    ecc_decoder i_dec (
        .code_in    (rd_code),
        .data_out   (rd_data),
        .single_err (dec_single),
        .double_err (dec_double)
    );

    // Flags only mean something alongside a valid read.
    always_comb begin
        err_corr   = rd_valid && dec_single;
        err_uncorr = rd_valid && dec_double;
    end
endmodule

// File: rtl/ecc_sram_checker.sv
// Protocol checks for the error-correcting memory, bound into the top module.
// Assumes the bench keeps enables low while reset is held.
module ecc_sram_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        err_corr,
    input logic        err_uncorr
);
    // Valid follows an accepted read by exactly one cycle.
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_valid == $past(rd_en && !sleep)));

    // Read data holds when no read was accepted.
    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en && !sleep)) |-> $stable(rd_data));

    // Sleep refuses reads.
    assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rd_valid);

    // Corrected and uncorrectable never together.
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));

    // Flags only accompany a valid read.
    assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr) |-> rd_valid);
endmodule

bind ecc_sram_top ecc_sram_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr)
);

// File: tb/test_ecc_sram_top.sv
// Directed bench for the error-correcting memory: one task per scenario.
// Inputs change on falling edges and outputs are sampled on falling edges.
module test_ecc_sram_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [38:0] flip_mask = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        err_corr;
    logic        err_uncorr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_sram_top i_ecc_sram_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_data    (wr_data),
        .flip_mask  (flip_mask),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .err_corr   (err_corr),
        .err_uncorr (err_uncorr)
    );

    // Generic comparison with one FAIL line on mismatch.
    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Data index for a codeword position per R1, or -1 for parity/check bits.
    function automatic int data_index(int p);
        int below;
        if (p == 0 || (p & (p - 1)) == 0) return -1;
        below = 0;
        for (int c = 1; c < p; c = c * 2) below++;
        return p - 1 - below;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [38:0] m);
        @(negedge clk);
        addr = a; wr_data = d; flip_mask = m; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flip_mask = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d,
                           output logic c, output logic u, output logic v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; c = err_corr; u = err_uncorr; v = rd_valid;
    endtask

    task automatic read_expect(string req, input logic [7:0] a, input logic [31:0] exp_d,
                               input logic exp_c, input logic exp_u);
        logic [31:0] d; logic c, u, v;
        do_read(a, d, c, u, v);
        check(req, "rd_valid", 64'(v), 64'(1));
        check(req, "rd_data", 64'(d), 64'(exp_d));
        check(req, "err_corr", 64'(c), 64'(exp_c));
        check(req, "err_uncorr", 64'(u), 64'(exp_u));
    endtask

    // R12: outputs quiet in and after reset.
    task automatic t_reset;
        check("R12", "rd_valid in reset", 64'(rd_valid), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R12", "rd_valid after reset", 64'(rd_valid), 64'(0));
        check("R12", "err_corr after reset", 64'(err_corr), 64'(0));
        check("R12", "err_uncorr after reset", 64'(err_uncorr), 64'(0));
    endtask

    // R2, R3, R7: clean writes and reads, single-cycle valid pulse.
    task automatic t_basic;
        logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h8000_0001};
        for (int i = 0; i < 4; i++) begin
            do_write(8'(8'h10 + i), pats[i], '0);
            read_expect("R3 R7", 8'(8'h10 + i), pats[i], 1'b0, 1'b0);
        end
        @(negedge clk);
        check("R2", "rd_valid drops after one cycle", 64'(rd_valid), 64'(0));
    endtask

    // R4, R5, R11: every single-bit flip position is repaired.
    task automatic t_single;
        logic [31:0] w = 32'h1357_9BDF;
        for (int p = 0; p < 39; p++) begin
            do_write(8'h22, w, 39'(1) << p);
            if (data_index(p) >= 0)
                read_expect("R4 R11", 8'h22, w, 1'b1, 1'b0);
            else
                read_expect("R5 R11", 8'h22, w, 1'b1, 1'b0);
        end
    endtask

    // R6, R1: double flips are flagged and data returned raw.
    task automatic t_double;
        int pa [5] = '{3, 0, 5, 38, 1};
        int pb [5] = '{5, 3, 4, 37, 32};
        logic [31:0] w = 32'hCAFE_F00D;
        logic [31:0] raw;
        for (int i = 0; i < 5; i++) begin
            raw = w;
            if (data_index(pa[i]) >= 0) raw[data_index(pa[i])] = ~raw[data_index(pa[i])];
            if (data_index(pb[i]) >= 0) raw[data_index(pb[i])] = ~raw[data_index(pb[i])];
            do_write(8'h33, w, (39'(1) << pa[i]) | (39'(1) << pb[i]));
            read_expect("R6 R1", 8'h33, raw, 1'b0, 1'b1);
        end
    endtask

    // R8: every address independent.
    task automatic t_banks;
        for (int a = 0; a < 256; a++)
            do_write(8'(a), {8'(a), 8'(~a), 8'(a * 7), 8'(a ^ 8'h5C)}, '0);
        for (int a = 0; a < 256; a += 17)
            read_expect("R8", 8'(a), {8'(a), 8'(~a), 8'(a * 7), 8'(a ^ 8'h5C)}, 1'b0, 1'b0);
        read_expect("R8", 8'hFF, {8'hFF, 8'h00, 8'(255 * 7), 8'(8'hFF ^ 8'h5C)}, 1'b0, 1'b0);
    endtask

    // R9: sleep refuses access and keeps contents; resume on first low edge.
    task automatic t_sleep;
        logic [31:0] d; logic c, u, v;
        do_write(8'h44, 32'h0BAD_BEEF, '0);
        @(negedge clk); sleep = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            addr = 8'h44; wr_data = 32'h1111_0000 + 32'(i); wr_en = 1'b1; rd_en = 1'b1;
            @(negedge clk);
            check("R9", "rd_valid in sleep", 64'(rd_valid), 64'(0));
            wr_en = 1'b0; rd_en = 1'b0;
        end
        @(negedge clk);
        sleep = 1'b0; addr = 8'h44; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9", "read accepted as sleep falls", 64'(rd_valid), 64'(1));
        check("R9", "contents kept over sleep", 64'(rd_data), 64'(32'h0BAD_BEEF));
        do_read(8'h44, d, c, u, v);
        check("R9", "no flags after sleep", 64'({c, u}), 64'(0));
    endtask

    // R10: read and write to one address at one edge.
    task automatic t_collide;
        do_write(8'h55, 32'hAAAA_0001, '0);
        @(negedge clk);
        addr = 8'h55; wr_data = 32'hBBBB_0002; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10", "old word on overlap", 64'(rd_data), 64'(32'hAAAA_0001));
        read_expect("R10", 8'h55, 32'hBBBB_0002, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_single();
        t_double();
        t_banks();
        t_sleep();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule